// File: doc/BRIEF.md
# Circular Undo/Redo Log Appender

This block sits beside a cache controller and turns every persistent store into a log record in a circular log held in uncacheable memory. Each store event brings a transaction number, a thread number, the physical address of the word, the word being written (redo value) and the word it replaces (undo value). The block queues the event in a small first-in, first-out buffer. It then writes the record to memory as four beats on a simple valid/acknowledge write port. Records leave in the order the stores were accepted.

The log has a fixed number of record slots. The block owns the tail index and advances it once a record has been fully written. Software owns the head index and moves it forward to release slots. A flag bit in every record marks the current pass around the log: it starts at one and inverts each time the tail wraps back to slot zero. A recovery routine can therefore tell freshly written records from stale or half-written ones. When every free slot is already claimed, the block stops accepting stores until software moves the head.

Top module: `txlog_appender`

## Requirements
- R1: Each record is four beats of DATA_W bits, in this order: a header beat, the physical address zero-extended, the new word, and the old word. In the header beat, bits [15:0] hold the transaction number, bits [23:16] the thread number, bit 24 the first-update flag, and bit DATA_W-1 the pass flag. All other header bits are zero.
- R2: The pass flag is 1 for records written during the first pass after reset. It inverts for every record written after each wrap of the tail from slot LOG_SIZE-1 to slot 0.
- R3: Records are written in the order their stores were accepted. A record's four beats are sent back to back, with no other record's beats interleaved.
- R4: Header bit 24 equals the st_first value presented with the store.
- R5: Beat k of the record in slot s is written at word address 4*s + k. Successive records use successive slots and wrap to slot 0 after slot LOG_SIZE-1.
- R6: Let r be the slot that the next accepted store will use. st_ready is low whenever (r+1) mod LOG_SIZE equals the head. While st_ready is low, a store presented with st_valid is ignored and produces no beat.
- R7: A beat's address and data stay stable while mem_wr_valid is high and mem_wr_ack is low. The tail advances only in the cycle after the fourth beat is acknowledged.
- R8: After reset, head and tail are 0, mem_wr_valid is low and st_ready is high. A software head write with a value of LOG_SIZE or more is ignored. The tail cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store event present |
| st_ready | output | 1 | Block can accept a store event |
| st_first | input | 1 | First update of this object in the transaction |
| st_txid | input | 16 | Transaction number |
| st_tid | input | 8 | Thread number |
| st_paddr | input | 48 | Physical address of the stored word |
| st_new | input | DATA_W | Word being written (redo) |
| st_old | input | DATA_W | Word being replaced (undo) |
| sw_head_we | input | 1 | Software head write strobe |
| sw_head_wdata | input | IDX_W | New head slot index |
| head_idx | output | IDX_W | Current head slot |
| tail_idx | output | IDX_W | Current tail slot |
| mem_wr_valid | output | 1 | Beat write request |
| mem_wr_addr | output | IDX_W+2 | Beat word address within the log |
| mem_wr_data | output | DATA_W | Beat data |
| mem_wr_ack | input | 1 | Memory accepts the current beat |

## Verification
The first pattern is a burst of four stores into an empty five-slot log. Every field, address and flag is compared beat by beat, which separates a correct header layout from a wrong one, and the burst ends with the log full so the back-pressure rule can be seen. Software then moves the head to release slots, and the stores that follow wrap past slot 4, so a pass flag that flips at the wrong record or never flips is exposed. A store held while the memory withholds acknowledge shows whether the tail moves early. A final burst wraps a second time, checking that the flag returns to its original value.

// File: rtl/txlog_pkg.sv
package txlog_pkg;

  localparam int TXID_W  = 16;
  localparam int TID_W   = 8;
  localparam int PADDR_W = 48;
  localparam int BEATS   = 4;

  // header beat bit positions
  localparam int HDR_TXID_LSB = 0;
  localparam int HDR_TID_LSB  = 16;
  localparam int HDR_FIRST    = 24;

  typedef struct packed {
    logic               first;
    logic [TXID_W-1:0]  txid;
    logic [TID_W-1:0]   tid;
    logic [PADDR_W-1:0] paddr;
  } rec_meta_t;

  localparam int META_W = $bits(rec_meta_t);

  typedef enum logic [1:0] {
    BEAT_HDR  = 2'd0,
    BEAT_ADDR = 2'd1,
    BEAT_NEW  = 2'd2,
    BEAT_OLD  = 2'd3
  } beat_e;

endpackage

// File: rtl/txlog_fifo.sv
module txlog_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);

  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;

  // storage has no reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rd_data = mem[rd_ptr[AW-1:0]];
  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);

  // R3: store order is kept only if no entry is lost or read twice
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);

endmodule

// File: rtl/txlog_beat_writer.sv
module txlog_beat_writer
  import txlog_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int LOG_SIZE = 1024,
  parameter int IDX_W    = 10,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rec_avail,
  input  rec_meta_t         rec_meta,
  input  logic [DATA_W-1:0] rec_new,
  input  logic [DATA_W-1:0] rec_old,
  output logic              rec_pop,
  output logic [IDX_W-1:0]  tail_idx,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(LOG_SIZE - 1);

  logic              busy_q;
  beat_e             beat_q;
  rec_meta_t         meta_q;
  logic [DATA_W-1:0] new_q, old_q;
  logic [IDX_W-1:0]  tail_q;
  logic              torn_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  function automatic logic [DATA_W-1:0] beat_word(
    input beat_e             b,
    input logic              torn,
    input rec_meta_t         m,
    input logic [DATA_W-1:0] nw,
    input logic [DATA_W-1:0] od
  );
    logic [DATA_W-1:0] w;
    w = '0;
    case (b)
      BEAT_HDR: begin
        w[HDR_TXID_LSB +: TXID_W] = m.txid;
        w[HDR_TID_LSB  +: TID_W]  = m.tid;
        w[HDR_FIRST]              = m.first;
        w[DATA_W-1]               = torn;
      end
      BEAT_ADDR: w[PADDR_W-1:0] = m.paddr;
      BEAT_NEW:  w = nw;
      default:   w = od;
    endcase
    return w;
  endfunction

  assign rec_pop = !busy_q && rec_avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      beat_q <= BEAT_HDR;
      meta_q <= '0;
      new_q  <= '0;
      old_q  <= '0;
      tail_q <= '0;
      torn_q <= 1'b1;
      addr_q <= '0;
      data_q <= '0;
    end else if (rec_pop) begin
      busy_q <= 1'b1;
      beat_q <= BEAT_HDR;
      meta_q <= rec_meta;
      new_q  <= rec_new;
      old_q  <= rec_old;
      addr_q <= {tail_q, 2'b00};
      data_q <= beat_word(BEAT_HDR, torn_q, rec_meta, rec_new, rec_old);
    end else if (busy_q && mem_wr_ack) begin
      if (beat_q == BEAT_OLD) begin
        busy_q <= 1'b0;
        if (tail_q == LAST_SLOT) begin
          tail_q <= '0;
          torn_q <= ~torn_q;
        end else begin
          tail_q <= tail_q + 1'b1;
        end
      end else begin
        beat_q <= beat_e'(beat_q + 2'd1);
        addr_q <= addr_q + 1'b1;
        data_q <= beat_word(beat_e'(beat_q + 2'd1), torn_q, meta_q, new_q, old_q);
      end
    end
  end

  assign tail_idx     = tail_q;
  assign mem_wr_valid = busy_q;
  assign mem_wr_addr  = addr_q;
  assign mem_wr_data  = data_q;

  assert_beat_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ack) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_tail_after_last_ack_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(tail_q) |-> $past(mem_wr_ack && mem_wr_valid && beat_q == BEAT_OLD));

  assert_torn_flip_at_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(torn_q) |-> (tail_q == '0));

  assert_addr_in_log_R5: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (32'(mem_wr_addr) < LOG_SIZE * BEATS));

endmodule

// File: rtl/txlog_appender.sv
module txlog_appender
  import txlog_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int LOG_SIZE  = 1024,
  parameter int BUF_DEPTH = 4,
  parameter int IDX_W     = $clog2(LOG_SIZE),
  parameter int ADDR_W    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic              st_first,
  input  logic [15:0]       st_txid,
  input  logic [7:0]        st_tid,
  input  logic [47:0]       st_paddr,
  input  logic [DATA_W-1:0] st_new,
  input  logic [DATA_W-1:0] st_old,
  input  logic              sw_head_we,
  input  logic [IDX_W-1:0]  sw_head_wdata,
  output logic [IDX_W-1:0]  head_idx,
  output logic [IDX_W-1:0]  tail_idx,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack
);

  localparam int ENTRY_W = META_W + 2 * DATA_W;
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(LOG_SIZE - 1);

  logic [IDX_W-1:0]   head_q;
  logic [IDX_W-1:0]   rsv_q;      // slot the next accepted store will use
  logic [IDX_W-1:0]   rsv_next;
  logic               log_full;
  logic               accept;
  logic               buf_empty, buf_full, buf_pop;
  logic [ENTRY_W-1:0] buf_wdata, buf_rdata;
  rec_meta_t          in_meta, out_meta;
  logic [DATA_W-1:0]  out_new, out_old;

  assign rsv_next = (rsv_q == LAST_SLOT) ? '0 : rsv_q + 1'b1;
  assign log_full = (rsv_next == head_q);
  assign st_ready = !log_full && !buf_full;
  assign accept   = st_valid && st_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      rsv_q  <= '0;
    end else begin
      if (sw_head_we && (32'(sw_head_wdata) < LOG_SIZE)) head_q <= sw_head_wdata;
      if (accept) rsv_q <= rsv_next;
    end
  end

  assign in_meta   = '{first: st_first, txid: st_txid, tid: st_tid, paddr: st_paddr};
  assign buf_wdata = {in_meta, st_new, st_old};
  assign {out_meta, out_new, out_old} = buf_rdata;

  txlog_fifo #(
    .W     (ENTRY_W),
    .DEPTH (BUF_DEPTH)
  ) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (accept),
    .wr_data (buf_wdata),
    .rd_en   (buf_pop),
    .rd_data (buf_rdata),
    .empty   (buf_empty),
    .full    (buf_full)
  );

  txlog_beat_writer #(
    .DATA_W   (DATA_W),
    .LOG_SIZE (LOG_SIZE),
    .IDX_W    (IDX_W),
    .ADDR_W   (ADDR_W)
  ) u_writer (
    .clk          (clk),
    .rst          (rst),
    .rec_avail    (!buf_empty),
    .rec_meta     (out_meta),
    .rec_new      (out_new),
    .rec_old      (out_old),
    .rec_pop      (buf_pop),
    .tail_idx     (tail_idx),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ack   (mem_wr_ack)
  );

  assign head_idx = head_q;

  // R6: the reservation never lands on the head slot through an accept
  assert_no_log_overrun_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && !sw_head_we) |=> (rsv_q != head_q));

endmodule

// File: tb/txlog_appender_tb.sv
module txlog_appender_tb;

  localparam int DATA_W    = 64;
  localparam int LOG_SIZE  = 5;
  localparam int BUF_DEPTH = 4;
  localparam int IDX_W     = 3;
  localparam int ADDR_W    = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              st_valid = 1'b0;
  logic              st_ready;
  logic              st_first = 1'b0;
  logic [15:0]       st_txid = '0;
  logic [7:0]        st_tid = '0;
  logic [47:0]       st_paddr = '0;
  logic [DATA_W-1:0] st_new = '0;
  logic [DATA_W-1:0] st_old = '0;
  logic              sw_head_we = 1'b0;
  logic [IDX_W-1:0]  sw_head_wdata = '0;
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic              mem_wr_valid;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [DATA_W-1:0] mem_wr_data;
  logic              mem_wr_ack = 1'b0;

  always #5 clk = ~clk;

  txlog_appender #(
    .DATA_W    (DATA_W),
    .LOG_SIZE  (LOG_SIZE),
    .BUF_DEPTH (BUF_DEPTH),
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W)
  ) u_dut (
    .clk           (clk),
    .rst           (rst),
    .st_valid      (st_valid),
    .st_ready      (st_ready),
    .st_first      (st_first),
    .st_txid       (st_txid),
    .st_tid        (st_tid),
    .st_paddr      (st_paddr),
    .st_new        (st_new),
    .st_old        (st_old),
    .sw_head_we    (sw_head_we),
    .sw_head_wdata (sw_head_wdata),
    .head_idx      (head_idx),
    .tail_idx      (tail_idx),
    .mem_wr_valid  (mem_wr_valid),
    .mem_wr_addr   (mem_wr_addr),
    .mem_wr_data   (mem_wr_data),
    .mem_wr_ack    (mem_wr_ack)
  );

  int checks = 0;
  int fails  = 0;
  int beats_seen = 0;
  bit done = 1'b0;
  bit ack_en = 1'b1;

  logic [DATA_W-1:0] exp_data[$];
  logic [ADDR_W-1:0] exp_addr[$];
  int  exp_slot = 0;
  logic exp_torn = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: presents one store and records its four expected beats
  task automatic send(input int n, input bit first);
    logic [DATA_W-1:0] hdr;
    @(negedge clk);
    st_valid = 1'b1;
    st_first = first;
    st_txid  = 16'h1000 + 16'(n);
    st_tid   = 8'(n * 3 + 1);
    st_paddr = 48'hA0_0000_0000 + 48'(n * 8);
    st_new   = 64'h5EED_0000_0000_0000 + 64'(n);
    st_old   = 64'h01D0_0000_0000_0000 + 64'(n);
    while (!st_ready) @(negedge clk);
    hdr = '0;
    hdr[15:0]  = st_txid;
    hdr[23:16] = st_tid;
    hdr[24]    = first;
    hdr[DATA_W-1] = exp_torn;
    exp_data.push_back(hdr);
    exp_data.push_back({16'h0, st_paddr});
    exp_data.push_back(st_new);
    exp_data.push_back(st_old);
    for (int k = 0; k < 4; k++) exp_addr.push_back(ADDR_W'(exp_slot * 4 + k));
    if (exp_slot == LOG_SIZE - 1) begin
      exp_slot = 0;
      exp_torn = ~exp_torn;
    end else begin
      exp_slot++;
    end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  // monitor and memory model: decides acknowledge at the negedge, compares the beat it accepts
  always @(negedge clk) begin
    if (rst) begin
      mem_wr_ack = 1'b0;
    end else if (mem_wr_valid && ack_en && ($urandom % 4 != 0)) begin
      mem_wr_ack = 1'b1;
      beats_seen++;
      if (exp_data.size() == 0) begin
        chk(1'b0, "R6", "unexpected beat", 64'(mem_wr_data), 64'h0);
      end else begin
        logic [DATA_W-1:0] ed;
        logic [ADDR_W-1:0] ea;
        ed = exp_data.pop_front();
        ea = exp_addr.pop_front();
        chk(mem_wr_data == ed, "R1/R2/R3/R4", "beat data", mem_wr_data, ed);
        chk(mem_wr_addr == ea, "R5", "beat address", 64'(mem_wr_addr), 64'(ea));
      end
    end else begin
      mem_wr_ack = 1'b0;
    end
  end

  task automatic drain;
    int t = 0;
    while ((exp_data.size() != 0 || mem_wr_valid) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic write_head(input logic [IDX_W-1:0] v);
    @(negedge clk);
    sw_head_we = 1'b1;
    sw_head_wdata = v;
    @(negedge clk);
    sw_head_we = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(head_idx == 0, "R8", "head after reset", 64'(head_idx), 64'd0);
    chk(tail_idx == 0, "R8", "tail after reset", 64'(tail_idx), 64'd0);
    chk(!mem_wr_valid, "R8", "write valid after reset", 64'(mem_wr_valid), 64'd0);
    chk(st_ready, "R8", "ready after reset", 64'(st_ready), 64'd1);

    // burst of four fills the five-slot log (R6)
    for (int n = 0; n < 4; n++) send(n, n == 0);
    chk(!st_ready, "R6", "ready with log full", 64'(st_ready), 64'd0);
    // a store presented while not ready must leave no trace
    @(negedge clk);
    st_valid = 1'b1;
    st_txid  = 16'hDEAD;
    repeat (10) @(negedge clk);
    st_valid = 1'b0;
    drain();
    chk(beats_seen == 16, "R6", "beats after blocked store", 64'(beats_seen), 64'd16);
    chk(tail_idx == 4, "R5", "tail after burst", 64'(tail_idx), 64'd4);

    // out-of-range head write is ignored (R8)
    write_head(3'd7);
    chk(head_idx == 0, "R8", "head after bad write", 64'(head_idx), 64'd0);
    chk(!st_ready, "R6", "ready still low", 64'(st_ready), 64'd0);
    write_head(3'd3);
    chk(head_idx == 3, "R8", "head after write", 64'(head_idx), 64'd3);
    chk(st_ready, "R6", "ready after release", 64'(st_ready), 64'd1);

    // wrap: slots 4,0,1; pass flag flips at slot 0 (R2)
    for (int n = 4; n < 7; n++) send(n, n == 5);
    chk(!st_ready, "R6", "ready full after wrap", 64'(st_ready), 64'd0);
    drain();
    chk(tail_idx == 2, "R5", "tail after wrap", 64'(tail_idx), 64'd2);

    // withheld acknowledge keeps the tail in place (R7)
    write_head(3'd2);
    ack_en = 1'b0;
    send(7, 1'b1);
    repeat (12) @(negedge clk);
    chk(tail_idx == 2, "R7", "tail while ack held", 64'(tail_idx), 64'd2);
    chk(mem_wr_valid, "R7", "valid while ack held", 64'(mem_wr_valid), 64'd1);
    ack_en = 1'b1;
    drain();
    chk(tail_idx == 3, "R7", "tail after ack", 64'(tail_idx), 64'd3);

    // second wrap: slots 3,4,0,1; flag returns to 1 (R2)
    write_head(3'd3);
    for (int n = 8; n < 12; n++) send(n, n == 10);
    chk(!st_ready, "R6", "ready full second pass", 64'(st_ready), 64'd0);
    drain();
    chk(tail_idx == 2, "R2", "tail after second wrap", 64'(tail_idx), 64'd2);
    chk(beats_seen == 48, "R3", "total beats", 64'(beats_seen), 64'd48);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule